// File: doc/BRIEF.md
# Instrument Status Byte Register

This block collects the condition of a measurement instrument into one 8-bit status byte and raises a service request towards the host. Some bits are sticky flags with set and clear events of their own. Some bits follow a live level from the acquisition side. One bit summarises an event register through an enable mask. The request bit latches when a masked summary of the other bits rises, and a poll or status query clears it.

The block also holds an 8-bit event register and an 8-bit enable mask for that register. The event register is made of sticky flags that a read-and-clear strobe empties. The enable mask can be written, cleared and read back. A poll strobe stores the status byte as it stood in the poll cycle, so the host reads the request bit before the poll clears it.

Top module: `instr_status_unit`

## Requirements
- R1: Bit 7 (overrun) sets one cycle after an `ovr_evt` pulse. It clears one cycle after a cycle in which `buf_empty` or `flush_cmd` is high, unless `ovr_evt` is high in that same cycle, in which case the set wins.
- R2: Bit 1 (triggered) sets one cycle after a `trig_evt` pulse. It clears one cycle after `acq_done` or `trig_reconf`, unless `trig_evt` is high in that same cycle, in which case the set wins.
- R3: Level bits follow their inputs in the same cycle: bit 4 equals `oq_nonempty`, bit 3 equals `scan_ready`, bit 2 equals the inverse of `cmd_busy`, and bit 0 equals `alarm_lvl`.
- R4: Each bit of `esr_q` is sticky. It sets one cycle after the matching bit of `esr_evt` is high and clears one cycle after `esr_rdclr`. A set and a clear in the same cycle leave the bit set.
- R5: `ese_q` loads `ese_wdata` one cycle after `ese_wr` and becomes zero one cycle after `ese_clr`. When both are high, the clear wins.
- R6: Bit 5 is high exactly when `esr_q & ese_q` is nonzero.
- R7: Bit 6 sets one cycle after the OR of (status byte with bit 6 forced low) AND `sre_mask` goes from 0 to 1. Bit 6 of `sre_mask` has no effect. `srq` equals bit 6. If this rise and a poll fall in the same cycle, the set wins.
- R8: One cycle after `poll_rd`, `poll_val` holds the status byte from the poll cycle, with bit 6 as it was before the clear. Bit 6 is then low unless R7 set it again in that same cycle.
- R9: After a synchronous reset, bits 7, 6, 5 and 1 are zero, and `esr_q`, `ese_q` and `poll_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_evt | input | 1 | Acquisition buffer overrun pulse |
| buf_empty | input | 1 | Acquisition buffer is empty (level) |
| flush_cmd | input | 1 | Buffer flush command pulse |
| trig_evt | input | 1 | Valid trigger start or stop detected (pulse) |
| acq_done | input | 1 | Acquisition complete pulse |
| trig_reconf | input | 1 | Trigger or stop setting changed (pulse) |
| oq_nonempty | input | 1 | Output queue holds data (level) |
| scan_ready | input | 1 | At least one complete scan is buffered (level) |
| cmd_busy | input | 1 | A command line is being processed (level) |
| alarm_lvl | input | 1 | Alarm condition present (level) |
| esr_evt | input | 8 | Per-bit event pulses for the event register |
| esr_rdclr | input | 1 | Read-and-clear strobe for the event register |
| ese_wr | input | 1 | Enable mask write strobe |
| ese_wdata | input | 8 | Enable mask write data |
| ese_clr | input | 1 | Enable mask clear strobe |
| sre_mask | input | 8 | Service request enable mask |
| poll_rd | input | 1 | Poll or status query strobe |
| stat_byte | output | 8 | Current status byte |
| srq | output | 1 | Service request |
| poll_val | output | 8 | Status byte stored by the last poll |
| esr_q | output | 8 | Event register contents |
| ese_q | output | 8 | Enable mask contents |

## Verification
The bench aims at collisions of priority. An overrun in the same cycle as an empty buffer, a trigger in the same cycle as an acquisition-complete pulse, an event in the same cycle as a read-and-clear, and an enable write in the same cycle as an enable clear each test which side wins. A wrong priority would drop a flag that should stay or keep a mask that should be gone. For the request bit, the bench checks three things. A condition that stays high must not raise a second request after a poll, which catches a level detector used where an edge detector belongs. A poll in the same cycle as a new rise must leave the request set. A mask that enables only bit 6 must never raise a request, since that would let the request bit feed on itself. The poll capture is compared with the byte seen just before the poll, so a design that stores the value after the clear shows bit 6 low.

// File: rtl/isb_pkg.sv
package isb_pkg;
    localparam int SB_W = 8;

    // Positions inside the status byte (host software decodes these)
    localparam int B_OVF  = 7;
    localparam int B_RQS  = 6;
    localparam int B_ESB  = 5;
    localparam int B_MAV  = 4;
    localparam int B_SCAN = 3;
    localparam int B_RDY  = 2;
    localparam int B_TRIG = 1;
    localparam int B_ALM  = 0;

    typedef logic [SB_W-1:0] sbyte_t;

    typedef struct packed {
        logic ovf;
        logic rqs;
        logic esb;
        logic mav;
        logic scan;
        logic rdy;
        logic trig;
        logic alm;
    } stat_t;

    function automatic logic any_masked(sbyte_t val, sbyte_t msk);
        return |(val & msk);
    endfunction

    function automatic sbyte_t drop_bit(sbyte_t val, int pos);
        sbyte_t r;
        r = val;
        r[pos] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/isb_sticky.sv
module isb_sticky #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    generate
        if (SET_WINS) begin : g_set_first
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (set_i) q <= 1'b1;
                else if (clr_i) q <= 1'b0;
            end
        end else begin : g_clr_first
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (clr_i) q <= 1'b0;
                else if (set_i) q <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/isb_evt_regs.sv
module isb_evt_regs
    import isb_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         rdclr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         en_clr,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] en_q,
    output logic         summary
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_ev
            isb_sticky #(.SET_WINS(1'b1)) u_bit (
                .clk  (clk),
                .rst  (rst),
                .set_i(evt[i]),
                .clr_i(rdclr),
                .q    (ev_q[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (en_clr) en_q <= '0;
        else if (en_wr)  en_q <= en_wdata;
    end

    assign summary = |(ev_q & en_q);
endmodule

// File: rtl/isb_srq.sv
module isb_srq
    import isb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sbyte_t cur_byte,
    input  sbyte_t req_mask,
    input  logic   poll,
    output logic   rqs,
    output sbyte_t cap
);
    logic   hit;
    logic   hit_q;
    logic   rise;

    assign hit  = any_masked(drop_bit(cur_byte, B_RQS), req_mask);
    assign rise = hit & ~hit_q;

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= hit;
    end

    isb_sticky #(.SET_WINS(1'b1)) u_rqs (
        .clk  (clk),
        .rst  (rst),
        .set_i(rise),
        .clr_i(poll),
        .q    (rqs)
    );

    always_ff @(posedge clk) begin
        if (rst)       cap <= '0;
        else if (poll) cap <= cur_byte;
    end
endmodule

// File: rtl/instr_status_unit.sv
module instr_status_unit
    import isb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ovr_evt,
    input  logic       buf_empty,
    input  logic       flush_cmd,
    input  logic       trig_evt,
    input  logic       acq_done,
    input  logic       trig_reconf,
    input  logic       oq_nonempty,
    input  logic       scan_ready,
    input  logic       cmd_busy,
    input  logic       alarm_lvl,
    input  logic [7:0] esr_evt,
    input  logic       esr_rdclr,
    input  logic       ese_wr,
    input  logic [7:0] ese_wdata,
    input  logic       ese_clr,
    input  logic [7:0] sre_mask,
    input  logic       poll_rd,
    output logic [7:0] stat_byte,
    output logic       srq,
    output logic [7:0] poll_val,
    output logic [7:0] esr_q,
    output logic [7:0] ese_q
);
    stat_t  st;
    logic   ovf_q, trig_q, esb, rqs_q;
    sbyte_t cap;

    isb_sticky #(.SET_WINS(1'b1)) u_ovf (
        .clk  (clk),
        .rst  (rst),
        .set_i(ovr_evt),
        .clr_i(buf_empty | flush_cmd),
        .q    (ovf_q)
    );

    isb_sticky #(.SET_WINS(1'b1)) u_trig (
        .clk  (clk),
        .rst  (rst),
        .set_i(trig_evt),
        .clr_i(acq_done | trig_reconf),
        .q    (trig_q)
    );

    isb_evt_regs #(.W(SB_W)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .evt     (esr_evt),
        .rdclr   (esr_rdclr),
        .en_wr   (ese_wr),
        .en_wdata(ese_wdata),
        .en_clr  (ese_clr),
        .ev_q    (esr_q),
        .en_q    (ese_q),
        .summary (esb)
    );

    always_comb begin
        st.ovf  = ovf_q;
        st.rqs  = rqs_q;
        st.esb  = esb;
        st.mav  = oq_nonempty;
        st.scan = scan_ready;
        st.rdy  = ~cmd_busy;
        st.trig = trig_q;
        st.alm  = alarm_lvl;
    end

    isb_srq u_srq (
        .clk     (clk),
        .rst     (rst),
        .cur_byte(sbyte_t'(st)),
        .req_mask(sre_mask),
        .poll    (poll_rd),
        .rqs     (rqs_q),
        .cap     (cap)
    );

    assign stat_byte = sbyte_t'(st);
    assign srq       = rqs_q;
    assign poll_val  = cap;
endmodule

// File: rtl/isb_chk.sv
module isb_chk (
    input logic       clk,
    input logic       rst,
    input logic       ovr_evt,
    input logic       buf_empty,
    input logic       flush_cmd,
    input logic       trig_evt,
    input logic       acq_done,
    input logic       trig_reconf,
    input logic [7:0] esr_evt,
    input logic       esr_rdclr,
    input logic       ese_clr,
    input logic       poll_rd,
    input logic [7:0] stat_byte,
    input logic [7:0] poll_val,
    input logic [7:0] esr_q,
    input logic [7:0] ese_q
);
    // R1
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> stat_byte[7]);
    // R1
    ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((buf_empty || flush_cmd) && !ovr_evt) |=> !stat_byte[7]);
    // R2
    trig_set_chk: assert property (@(posedge clk) disable iff (rst)
        trig_evt |=> stat_byte[1]);
    // R2
    trig_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((acq_done || trig_reconf) && !trig_evt) |=> !stat_byte[1]);
    // R4
    esr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !esr_rdclr |=> ((esr_q & $past(esr_q)) == $past(esr_q)));
    // R4
    esr_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (esr_evt != 8'h00) |=> ((esr_q & $past(esr_evt)) == $past(esr_evt)));
    // R5
    ese_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ese_clr |=> (ese_q == 8'h00));
    // R6
    esb_sum_chk: assert property (@(posedge clk) disable iff (rst)
        stat_byte[5] == ((esr_q & ese_q) != 8'h00));
    // R8
    poll_cap_chk: assert property (@(posedge clk) disable iff (rst)
        poll_rd |=> (poll_val == $past(stat_byte)));
endmodule

bind instr_status_unit isb_chk u_isb_chk (
    .clk        (clk),
    .rst        (rst),
    .ovr_evt    (ovr_evt),
    .buf_empty  (buf_empty),
    .flush_cmd  (flush_cmd),
    .trig_evt   (trig_evt),
    .acq_done   (acq_done),
    .trig_reconf(trig_reconf),
    .esr_evt    (esr_evt),
    .esr_rdclr  (esr_rdclr),
    .ese_clr    (ese_clr),
    .poll_rd    (poll_rd),
    .stat_byte  (stat_byte),
    .poll_val   (poll_val),
    .esr_q      (esr_q),
    .ese_q      (ese_q)
);

// File: tb/tb_instr_status_unit.sv
module tb_instr_status_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovr_evt = 0, buf_empty = 0, flush_cmd = 0;
    logic       trig_evt = 0, acq_done = 0, trig_reconf = 0;
    logic       oq_nonempty = 0, scan_ready = 0, cmd_busy = 0, alarm_lvl = 0;
    logic [7:0] esr_evt = '0;
    logic       esr_rdclr = 0, ese_wr = 0, ese_clr = 0, poll_rd = 0;
    logic [7:0] ese_wdata = '0, sre_mask = '0;
    logic [7:0] stat_byte, poll_val, esr_q, ese_q;
    logic       srq;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    instr_status_unit dut (
        .clk(clk), .rst(rst), .ovr_evt(ovr_evt), .buf_empty(buf_empty),
        .flush_cmd(flush_cmd), .trig_evt(trig_evt), .acq_done(acq_done),
        .trig_reconf(trig_reconf), .oq_nonempty(oq_nonempty),
        .scan_ready(scan_ready), .cmd_busy(cmd_busy), .alarm_lvl(alarm_lvl),
        .esr_evt(esr_evt), .esr_rdclr(esr_rdclr), .ese_wr(ese_wr),
        .ese_wdata(ese_wdata), .ese_clr(ese_clr), .sre_mask(sre_mask),
        .poll_rd(poll_rd), .stat_byte(stat_byte), .srq(srq),
        .poll_val(poll_val), .esr_q(esr_q), .ese_q(ese_q)
    );

    // stimulus [3:0] = {oq_nonempty, scan_ready, cmd_busy, alarm_lvl}
    // expected [7:4] = {bit4, bit3, bit2, bit0}
    localparam logic [7:0] LVL_VEC [6] = '{
        8'b0010_0000, 8'b1010_1000, 8'b0110_0100,
        8'b0000_0010, 8'b0011_0001, 8'b1101_1111
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pre;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R9 reset state
        chk("R9 stat", stat_byte, 8'h04);
        chk("R9 esr", esr_q, 8'h00);
        chk("R9 ese", ese_q, 8'h00);
        chk("R9 poll", poll_val, 8'h00);
        chk("R9 srq", {7'd0, srq}, 8'h00);

        // R3 level vector table
        for (int k = 0; k < 6; k++) begin
            {oq_nonempty, scan_ready, cmd_busy, alarm_lvl} = LVL_VEC[k][3:0];
            #1;
            chk("R3 levels", {4'd0, stat_byte[4], stat_byte[3], stat_byte[2], stat_byte[0]},
                {4'd0, LVL_VEC[k][7:4]});
            step();
        end
        {oq_nonempty, scan_ready, cmd_busy, alarm_lvl} = 4'b0000;

        // R1 overrun
        ovr_evt = 1; step(); ovr_evt = 0;
        chk("R1 set", {7'd0, stat_byte[7]}, 8'h01);
        step(); chk("R1 hold", {7'd0, stat_byte[7]}, 8'h01);
        flush_cmd = 1; step(); flush_cmd = 0;
        chk("R1 flush", {7'd0, stat_byte[7]}, 8'h00);
        ovr_evt = 1; buf_empty = 1; step(); ovr_evt = 0;
        chk("R1 set wins", {7'd0, stat_byte[7]}, 8'h01);
        step(); buf_empty = 0;
        chk("R1 drain", {7'd0, stat_byte[7]}, 8'h00);

        // R2 triggered
        trig_evt = 1; step(); trig_evt = 0;
        chk("R2 set", {7'd0, stat_byte[1]}, 8'h01);
        acq_done = 1; step(); acq_done = 0;
        chk("R2 done", {7'd0, stat_byte[1]}, 8'h00);
        trig_evt = 1; step(); trig_evt = 0;
        trig_reconf = 1; step(); trig_reconf = 0;
        chk("R2 reconf", {7'd0, stat_byte[1]}, 8'h00);
        trig_evt = 1; acq_done = 1; step(); trig_evt = 0; acq_done = 0;
        chk("R2 set wins", {7'd0, stat_byte[1]}, 8'h01);
        acq_done = 1; step(); acq_done = 0;

        // R4 event register
        esr_evt = 8'h05; step(); esr_evt = 8'h00;
        chk("R4 set", esr_q, 8'h05);
        esr_evt = 8'h20; step(); esr_evt = 8'h00;
        chk("R4 sticky", esr_q, 8'h25);
        esr_rdclr = 1; step(); esr_rdclr = 0;
        chk("R4 clear", esr_q, 8'h00);
        esr_evt = 8'h81; esr_rdclr = 1; step(); esr_evt = 8'h00; esr_rdclr = 0;
        chk("R4 set wins", esr_q, 8'h81);
        esr_rdclr = 1; step(); esr_rdclr = 0;

        // R5 enable mask
        ese_wr = 1; ese_wdata = 8'h3C; step(); ese_wr = 0;
        chk("R5 write", ese_q, 8'h3C);
        ese_clr = 1; step(); ese_clr = 0;
        chk("R5 clear", ese_q, 8'h00);
        ese_wr = 1; ese_clr = 1; ese_wdata = 8'hFF; step(); ese_wr = 0; ese_clr = 0;
        chk("R5 clear wins", ese_q, 8'h00);
        ese_wr = 1; ese_wdata = 8'h01; step(); ese_wr = 0;
        chk("R5 readback", ese_q, 8'h01);

        // R6 summary bit
        chk("R6 empty", {7'd0, stat_byte[5]}, 8'h00);
        esr_evt = 8'h01; step(); esr_evt = 8'h00;
        chk("R6 enabled", {7'd0, stat_byte[5]}, 8'h01);
        esr_rdclr = 1; step(); esr_rdclr = 0;
        esr_evt = 8'h02; step(); esr_evt = 8'h00;
        chk("R6 masked off", {7'd0, stat_byte[5]}, 8'h00);
        esr_rdclr = 1; step(); esr_rdclr = 0;

        // R7 / R8 service request
        sre_mask = 8'h01; step();
        chk("R7 idle", {7'd0, srq}, 8'h00);
        alarm_lvl = 1; step();
        chk("R7 rise", {7'd0, srq}, 8'h01);
        chk("R7 bit6", {7'd0, stat_byte[6]}, 8'h01);
        pre = stat_byte;
        poll_rd = 1; step(); poll_rd = 0;
        chk("R8 capture", poll_val, pre);
        chk("R8 cap bit6", {7'd0, poll_val[6]}, 8'h01);
        chk("R8 cleared", {7'd0, srq}, 8'h00);
        step(); step();
        chk("R7 level no re-raise", {7'd0, srq}, 8'h00);
        alarm_lvl = 0; step();
        alarm_lvl = 1; poll_rd = 1; step(); poll_rd = 0;
        chk("R7 rise beats poll", {7'd0, srq}, 8'h01);
        sre_mask = 8'h40; alarm_lvl = 0;
        poll_rd = 1; step(); poll_rd = 0;
        step(); step(); step();
        chk("R7 mask bit6 no effect", {7'd0, srq}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule